// File: doc/BRIEF.md
# Guarded Pad Pull and Function Control Register Bank

This block is the control register bank for one eight-pin general-purpose I/O port. It keeps four per-pin fields: a weak pull-up enable, a weak pull-down enable, an alternate-function select and a digital-input enable. All four drive the pad control outputs. On any pin the pull-up and the pull-down never hold 1 together. A 1 written to one of them clears the other one for that pin.

The pull-up, alternate-function and digital-enable fields are guarded per bit. A write lands only while the key register is unlocked and the matching bit of the permission mask is 1. The key register is unlocked by writing a 32-bit key, which is a parameter. Any other value written to it locks it again. The permission mask can only be changed while the bank is unlocked.

A port that carries the four debug pins is built with `DEBUG_PORT = 1`. On such a port, pins 3:0 reset to their debug function and cannot be changed until software opens their mask bits. Every stored value reaches its pad output two clock edges after the write is taken. Reads always return the stored value.

Top module: `gpio_pad_ctrl_regs`

## Requirements
- R1: The pull-up field sits at byte offset 0x510, bits 7:0, and is read/write. Bits 31:8 of that word read as zero, whatever value was written to them.
- R2: For each bit n, a 1 written to bit n of the pull-up field clears bit n of the pull-down field, and a 1 written to bit n of the pull-down field clears bit n of the pull-up field. A bit written as 0 clears only its own field and leaves the other field unchanged.
- R3: A change to any stored field appears on the matching pad output on the second rising edge after the edge that takes the write.
- R4: For each bit n, a write to the pull-up (0x510), alternate-function (0x420) or digital-enable (0x51C) field changes bit n only when the bank is unlocked and permission-mask bit n is 1. Otherwise bit n keeps its value.
- R5: The key register (0x520) resets locked. Writing the key value UNLOCK_KEY unlocks it, and any other written value locks it. It reads 1 when locked and 0 when unlocked.
- R6: The permission mask (0x524) changes only on writes made while the bank is unlocked. On an ordinary port it resets to 0xFF.
- R7: On an ordinary port the pull-up, alternate-function and digital-enable fields reset to 0x00. On a debug port they reset to 0x0F and the permission mask resets to 0xF0. The pull-down field always resets to 0x00.
- R8: The pull-down field is at 0x514. A read of any address not listed in these requirements returns 0.
- R9: Read data appears on the edge after the address is presented. It shows the stored value even when the pad outputs have not yet caught up.
- R10: Writes to the pull-down field are not guarded. They take effect whether the bank is locked or unlocked and whatever the permission mask holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset of the register being accessed |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pad_pull_up | output | PINS | Weak pull-up enable for each pin |
| pad_pull_down | output | PINS | Weak pull-down enable for each pin |
| pad_alt_sel | output | PINS | Alternate-function select for each pin |
| pad_dig_en | output | PINS | Digital-input enable for each pin |

## Verification
A stuck lock state shows up in one of two ways: guarded writes land while the bank is locked, or they are dropped while it is unlocked. Either is visible on the next read of the field and on the pads two edges later. A wrong permission-mask bit changes exactly one pin of a guarded field, so the tests write patterns that mix open and closed bits. A broken exclusion between pull-up and pull-down shows as both enables high on one pad, or as a pull bit that survives a write of 1 to its partner. A pipeline of the wrong depth moves the pad update one edge early or late, so the pads are sampled on both the first and the second edge after a write.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_ALT    = 12'h420;
  localparam logic [ADDR_W-1:0] OFF_PU     = 12'h510;
  localparam logic [ADDR_W-1:0] OFF_PD     = 12'h514;
  localparam logic [ADDR_W-1:0] OFF_DEN    = 12'h51C;
  localparam logic [ADDR_W-1:0] OFF_KEY    = 12'h520;
  localparam logic [ADDR_W-1:0] OFF_PERMIT = 12'h524;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_ALT, SEL_PU, SEL_PD, SEL_DEN, SEL_KEY, SEL_PERMIT
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    case (a)
      OFF_ALT:    return SEL_ALT;
      OFF_PU:     return SEL_PU;
      OFF_PD:     return SEL_PD;
      OFF_DEN:    return SEL_DEN;
      OFF_KEY:    return SEL_KEY;
      OFF_PERMIT: return SEL_PERMIT;
      default:    return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpr_lock_ctrl.sv
module gpr_lock_ctrl #(
  parameter int              PINS       = 8,
  parameter logic [31:0]     KEY        = 32'h6A09_E667,
  parameter logic [PINS-1:0] PERMIT_RST = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            key_wr,
  input  logic            permit_wr,
  input  logic [31:0]     wdata,
  output logic            locked,
  output logic [PINS-1:0] permit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b1;
    end else if (key_wr) begin
      locked <= (wdata != KEY);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      permit <= PERMIT_RST;
    end else if (permit_wr && !locked) begin
      permit <= wdata[PINS-1:0];
    end
  end
endmodule

// File: rtl/gpr_masked_reg.sv
module gpr_masked_reg #(
  parameter int              PINS = 8,
  parameter logic [PINS-1:0] RST  = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [PINS-1:0] wmask,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST;
    end else if (wr) begin
      q <= (q & ~wmask) | (wdata & wmask);
    end
  end
endmodule

// File: rtl/gpr_pull_pair.sv
module gpr_pull_pair #(
  parameter int              PINS   = 8,
  parameter logic [PINS-1:0] PU_RST = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pu_wr,
  input  logic            pd_wr,
  input  logic [PINS-1:0] pu_mask,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] pu_q,
  output logic [PINS-1:0] pd_q
);
  logic [PINS-1:0] pu_set, pu_clr, pd_set, pd_clr;

  always_comb begin
    pu_set = pu_wr ? (pu_mask & wdata)  : '0;
    pu_clr = pu_wr ? (pu_mask & ~wdata) : '0;
    pd_set = pd_wr ? wdata  : '0;
    pd_clr = pd_wr ? ~wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pu_q <= PU_RST;
      pd_q <= '0;
    end else begin
      pu_q <= (pu_q & ~pu_clr & ~pd_set) | pu_set;
      pd_q <= (pd_q & ~pd_clr & ~pu_set) | pd_set;
    end
  end
endmodule

// File: rtl/gpr_pad_pipe.sv
module gpr_pad_pipe #(
  parameter int              PINS   = 8,
  parameter int              STAGES = 2,
  parameter logic [PINS-1:0] RST    = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] d,
  output logic [PINS-1:0] q
);
  logic [STAGES:0][PINS-1:0] stg;
  assign stg[0] = d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[g+1] <= RST;
      else     stg[g+1] <= stg[g];
    end
  end

  assign q = stg[STAGES];
endmodule

// File: rtl/gpio_pad_ctrl_regs.sv
module gpio_pad_ctrl_regs
  import gpr_pkg::*;
#(
  parameter int              PINS       = 8,
  parameter logic [31:0]     UNLOCK_KEY = 32'h6A09_E667,
  parameter bit              DEBUG_PORT = 1'b0,
  parameter logic [PINS-1:0] DEBUG_MASK = 'hF,
  parameter int              PAD_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [PINS-1:0]   pad_pull_up,
  output logic [PINS-1:0]   pad_pull_down,
  output logic [PINS-1:0]   pad_alt_sel,
  output logic [PINS-1:0]   pad_dig_en
);
  localparam logic [PINS-1:0] FIELD_RST  = DEBUG_PORT ? DEBUG_MASK : '0;
  localparam logic [PINS-1:0] PERMIT_RST = DEBUG_PORT ? ~DEBUG_MASK : '1;
  localparam int              PAD_W      = DATA_W - PINS;

  reg_sel_e        sel;
  logic            locked;
  logic [PINS-1:0] permit_q, guard, pu_q, pd_q, alt_q, den_q;
  logic [DATA_W-1:0] rd_next;

  assign sel   = decode(bus_addr);
  assign guard = permit_q & {PINS{~locked}};

  gpr_lock_ctrl #(.PINS(PINS), .KEY(UNLOCK_KEY), .PERMIT_RST(PERMIT_RST)) u_lock (
    .clk(clk), .rst(rst),
    .key_wr(bus_wr && sel == SEL_KEY),
    .permit_wr(bus_wr && sel == SEL_PERMIT),
    .wdata(bus_wdata), .locked(locked), .permit(permit_q)
  );

  gpr_pull_pair #(.PINS(PINS), .PU_RST(FIELD_RST)) u_pull (
    .clk(clk), .rst(rst),
    .pu_wr(bus_wr && sel == SEL_PU), .pd_wr(bus_wr && sel == SEL_PD),
    .pu_mask(guard), .wdata(bus_wdata[PINS-1:0]),
    .pu_q(pu_q), .pd_q(pd_q)
  );

  gpr_masked_reg #(.PINS(PINS), .RST(FIELD_RST)) u_alt (
    .clk(clk), .rst(rst), .wr(bus_wr && sel == SEL_ALT),
    .wmask(guard), .wdata(bus_wdata[PINS-1:0]), .q(alt_q)
  );

  gpr_masked_reg #(.PINS(PINS), .RST(FIELD_RST)) u_den (
    .clk(clk), .rst(rst), .wr(bus_wr && sel == SEL_DEN),
    .wmask(guard), .wdata(bus_wdata[PINS-1:0]), .q(den_q)
  );

  gpr_pad_pipe #(.PINS(PINS), .STAGES(PAD_STAGES), .RST(FIELD_RST)) u_pipe_pu (
    .clk(clk), .rst(rst), .d(pu_q), .q(pad_pull_up));
  gpr_pad_pipe #(.PINS(PINS), .STAGES(PAD_STAGES), .RST('0)) u_pipe_pd (
    .clk(clk), .rst(rst), .d(pd_q), .q(pad_pull_down));
  gpr_pad_pipe #(.PINS(PINS), .STAGES(PAD_STAGES), .RST(FIELD_RST)) u_pipe_alt (
    .clk(clk), .rst(rst), .d(alt_q), .q(pad_alt_sel));
  gpr_pad_pipe #(.PINS(PINS), .STAGES(PAD_STAGES), .RST(FIELD_RST)) u_pipe_den (
    .clk(clk), .rst(rst), .d(den_q), .q(pad_dig_en));

  always_comb begin
    case (sel)
      SEL_ALT:    rd_next = {{PAD_W{1'b0}}, alt_q};
      SEL_PU:     rd_next = {{PAD_W{1'b0}}, pu_q};
      SEL_PD:     rd_next = {{PAD_W{1'b0}}, pd_q};
      SEL_DEN:    rd_next = {{PAD_W{1'b0}}, den_q};
      SEL_KEY:    rd_next = {{(DATA_W-1){1'b0}}, locked};
      SEL_PERMIT: rd_next = {{PAD_W{1'b0}}, permit_q};
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/gpr_checker.sv
module gpr_checker
  import gpr_pkg::*;
#(
  parameter int          PINS = 8,
  parameter logic [31:0] KEY  = 32'h6A09_E667
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [PINS-1:0]   pad_pull_up,
  input logic [PINS-1:0]   pad_pull_down,
  input logic              locked,
  input logic [PINS-1:0]   pu_q,
  input logic [PINS-1:0]   permit_q
);
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == OFF_PU) |=> (bus_rdata[DATA_W-1:PINS] == '0));

  p_pull_excl_r2: assert property (@(posedge clk) disable iff (rst)
    ((pad_pull_up & pad_pull_down) == '0));

  p_pad_lag_r3: assert property (@(posedge clk) disable iff (rst)
    pad_pull_up == $past(pu_q, 2));

  p_guard_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_PU && locked) |=> $stable(pu_q));

  p_relock_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_KEY && bus_wdata != KEY) |=> locked);

  p_unlock_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_KEY && bus_wdata == KEY) |=> !locked);

  p_permit_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_PERMIT && locked) |=> $stable(permit_q));

  p_unmapped_r8: assert property (@(posedge clk) disable iff (rst)
    (decode(bus_addr) == SEL_NONE) |=> (bus_rdata == '0));
endmodule

bind gpio_pad_ctrl_regs gpr_checker #(.PINS(PINS), .KEY(UNLOCK_KEY)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pad_pull_up(pad_pull_up), .pad_pull_down(pad_pull_down),
  .locked(locked), .pu_q(pu_q), .permit_q(permit_q)
);

// File: tb/tb_gpio_pad_ctrl_regs.sv
module tb_gpio_pad_ctrl_regs;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] KEY        = 32'h6A09_E667;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata, rdata_dbg;
  logic [7:0]  pu, pd, alt, den, pu_d, pd_d, alt_d, den_d;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pad_ctrl_regs #(.UNLOCK_KEY(KEY)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata),
    .pad_pull_up(pu), .pad_pull_down(pd), .pad_alt_sel(alt), .pad_dig_en(den));

  gpio_pad_ctrl_regs #(.UNLOCK_KEY(KEY), .DEBUG_PORT(1'b1)) dut_dbg (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_dbg),
    .pad_pull_up(pu_d), .pad_pull_down(pd_d), .pad_alt_sel(alt_d), .pad_dig_en(den_d));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    @(posedge clk); #1;
    d = rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R7 pad pu", {24'd0, pu}, 0);
    chk("R7 pad pd", {24'd0, pd}, 0);
    chk("R7 pad alt", {24'd0, alt}, 0);
    chk("R7 pad den", {24'd0, den}, 0);
    rd(12'h510, d); chk("R7 pu read", d, 0);
    rd(12'h514, d); chk("R8 pd read", d, 0);
    rd(12'h520, d); chk("R5 lock reads 1 after reset", d, 1);
    rd(12'h524, d); chk("R6 permit reset", d, 32'hFF);
  endtask

  task automatic t_debug_port;
    logic [31:0] d;
    chk("R7 dbg pad pu", {24'd0, pu_d}, 32'h0F);
    chk("R7 dbg pad alt", {24'd0, alt_d}, 32'h0F);
    chk("R7 dbg pad den", {24'd0, den_d}, 32'h0F);
    chk("R7 dbg pad pd", {24'd0, pd_d}, 0);
    rd(12'h524, d); chk("R7 dbg permit", rdata_dbg, 32'hF0);
  endtask

  task automatic t_locked_block;
    logic [31:0] d;
    wr(12'h510, 32'hFF);
    wr(12'h420, 32'hFF);
    wr(12'h524, 32'h00);
    rd(12'h510, d); chk("R4 pu locked", d, 0);
    rd(12'h420, d); chk("R4 alt locked", d, 0);
    rd(12'h524, d); chk("R6 permit locked", d, 32'hFF);
    step(2);
    chk("R4 pad pu locked", {24'd0, pu}, 0);
  endtask

  task automatic t_key;
    logic [31:0] d;
    wr(12'h520, KEY);
    rd(12'h520, d); chk("R5 unlock", d, 0);
    wr(12'h520, KEY ^ 32'h1);
    rd(12'h520, d); chk("R5 relock", d, 1);
    wr(12'h520, KEY);
    rd(12'h520, d); chk("R5 unlock again", d, 0);
  endtask

  task automatic t_pu_timing;
    logic [31:0] d;
    wr(12'h510, 32'hFFFF_FFA5);
    rd(12'h510, d);
    chk("R1 pu read masks reserved", d, 32'hA5);
    chk("R9 pad lags read", {24'd0, pu}, 0);
    step(1);
    chk("R3 pad on second edge", {24'd0, pu}, 32'hA5);
  endtask

  task automatic t_exclusion;
    logic [31:0] d;
    wr(12'h514, 32'h0F);
    rd(12'h514, d); chk("R2 pd set", d, 32'h0F);
    rd(12'h510, d); chk("R2 pd clears pu", d, 32'hA0);
    wr(12'h510, 32'h03);
    rd(12'h510, d); chk("R2 pu write", d, 32'h03);
    rd(12'h514, d); chk("R2 pu clears pd only where 1", d, 32'h0C);
    step(1);
    chk("R2 pad pu", {24'd0, pu}, 32'h03);
    chk("R2 pad pd", {24'd0, pd}, 32'h0C);
  endtask

  task automatic t_pd_unguarded;
    logic [31:0] d;
    wr(12'h520, 32'h0);
    wr(12'h514, 32'h01);
    rd(12'h514, d); chk("R10 pd written while locked", d, 32'h01);
    rd(12'h510, d); chk("R10 pd clears pu while locked", d, 32'h02);
  endtask

  task automatic t_permit_mask;
    logic [31:0] d;
    wr(12'h520, KEY);
    wr(12'h524, 32'hF0);
    rd(12'h524, d); chk("R6 permit write unlocked", d, 32'hF0);
    wr(12'h420, 32'hFF);
    wr(12'h51C, 32'h3C);
    wr(12'h510, 32'hFF);
    rd(12'h420, d); chk("R4 alt masked", d, 32'hF0);
    rd(12'h51C, d); chk("R4 den masked", d, 32'h30);
    rd(12'h510, d); chk("R4 pu masked", d, 32'hF2);
    rd(12'h514, d); chk("R4 masked pu leaves pd", d, 32'h01);
    step(1);
    chk("R3 pad alt", {24'd0, alt}, 32'hF0);
    chk("R3 pad den", {24'd0, den}, 32'h30);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(12'h000, d); chk("R8 unmapped 0x000", d, 0);
    rd(12'h518, d); chk("R8 unmapped 0x518", d, 0);
    rd(12'h511, d); chk("R8 unmapped 0x511", d, 0);
    rd(12'h528, d); chk("R8 unmapped 0x528", d, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_debug_port();
    t_locked_block();
    t_key();
    t_pu_timing();
    t_exclusion();
    t_pd_unguarded();
    t_permit_mask();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule